// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Host Controller

This block is the host end of a two-signal serial link to a store of eight 32-bit registers. The host drives a serial clock. A single data line carries traffic in both directions. A request gives a 4-bit command, a 3-bit register address and, for write-class commands, a 32-bit payload. The controller turns the request into a frame made of a start bit, the command, the address and any payload. For a read, it releases the data line for one turnaround clock and then captures the 32 bits that the target returns. Every frame ends with a trailer clock during which the data line is held low.

After each frame the controller stays busy for a programmable quiet interval, counted in system clocks, and only then accepts another request. Both the serial clock rate and the quiet interval are set by parameters. `DIV` gives the length of each serial clock half in system clocks, and `LOCKOUT` gives the quiet interval. The default `LOCKOUT` is 1,000,000 system clocks, which is 20 ms at 50 MHz. The reserved command 1101 is refused with an error pulse, and no frame is sent for it.

Top module: `ee2w_host`

## Requirements
- R1: After reset, `req_ready`=1, `scl`=0, `sda_o`=0, `sda_oe`=1, and `rsp_done`=`rsp_err`=0.
- R2: Every frame begins with the following fields, each taken by the target on a falling `scl` edge:
  - a start bit of 1;
  - the 4 command bits, MSB first;
  - the 3 address bits, MSB first.
- R3: Commands with bit 3 = 0 (0100, 0101, 0110, 0111) are followed by the 32 write-data bits, MSB first, driven by the host (`sda_oe`=1).
- R4: `scl` is low when idle. Each bit holds `scl` high for `DIV` system clocks and then low for `DIV` system clocks. `sda_o` and `sda_oe` change only in the cycle where `scl` rises.
- R5: Every frame ends with one trailer bit that has `sda_oe`=1 and `sda_o`=0.
- R6: For command 1100 (read), bit 8 is a turnaround clock and bits 9..40 carry the read data. `sda_oe`=0 over all 33 of these bits. `sda_i` is sampled on each falling `scl` edge of bits 9..40, MSB first.
- R7: Commands 1110, 1111 and 10xx have no data field. The trailer follows the address directly, so the frame is 9 bits long.
- R8: Command 1101 is accepted but refused. `rsp_err` pulses one cycle after acceptance, no `scl` edge occurs, and `req_ready` stays 1.
- R9: `rsp_done` is a one-cycle pulse that appears `2*DIV*N` cycles after the acceptance edge, where N is 41 for writes, 42 for reads and 9 for header-only commands.
- R10: When `rsp_done` is high, `rsp_rdata` holds the read data for a read, and 0 for any other command.
- R11: `req_ready` is 0 from acceptance through the frame. It stays 0 for `LOCKOUT` cycles after the `rsp_done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_cmd | input | 4 | Command code |
| req_addr | input | 3 | Register address |
| req_wdata | input | 32 | Write payload |
| rsp_done | output | 1 | Frame finished (one-cycle pulse) |
| rsp_err | output | 1 | Reserved command refused (one-cycle pulse) |
| rsp_rdata | output | 32 | Data captured by a read |
| scl | output | 1 | Serial clock |
| sda_o | output | 1 | Data line output value |
| sda_oe | output | 1 | Data line output enable |
| sda_i | input | 1 | Data line input value |

## Verification
The counting for every check starts at the system clock edge that accepts a request.
- `rsp_err` is due one cycle after that edge.
- `rsp_done` is due exactly `2*DIV*N` cycles after it, and `rsp_rdata` is checked in that same cycle.
- `req_ready` must return exactly `LOCKOUT` cycles after `rsp_done`.

The bench drives and samples on the falling system clock edge and counts those edges from acceptance, so each comparison lands in the cycle where the value is due. Frame bits are recorded on each falling `scl` edge, which is the target's own sampling point, and compared bit by bit against a frame the bench builds itself. Randomized commands, addresses and payloads are mixed with directed cases: the reserved code, a header-only erase, and all-ones and all-zeros data.

// File: rtl/ee2w_host.sv
module ee2w_host #(
  parameter int DIV     = 4,
  parameter int LOCKOUT = 1000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [3:0]  req_cmd,
  input  logic [2:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_done,
  output logic        rsp_err,
  output logic [31:0] rsp_rdata,
  output logic        scl,
  output logic        sda_o,
  output logic        sda_oe,
  input  logic        sda_i
);
  localparam int CW = $clog2(DIV + 1);
  localparam int LW = $clog2(LOCKOUT + 1);
  localparam logic [3:0] CMD_RD  = 4'b1100;
  localparam logic [3:0] CMD_RSV = 4'b1101;

  typedef enum logic [1:0] {IDLE, XFER, LOCK} st_t;
  st_t st;

  logic [CW-1:0] dcnt;
  logic [LW-1:0] lcnt;
  logic [5:0]    bitn, last;
  logic [39:0]   tx;
  logic [31:0]   rx;
  logic          is_rd, hi;

  wire acc    = req_valid && (st == IDLE);
  wire rsv    = (req_cmd == CMD_RSV);
  wire tick   = (dcnt == CW'(DIV - 1));
  wire rd_win = is_rd && (bitn >= 6'd8) && (bitn <= 6'd40);

  assign req_ready = (st == IDLE);
  assign scl       = hi;
  assign sda_o     = tx[39];
  assign sda_oe    = !rd_win;
  assign rsp_rdata = rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; dcnt <= '0; lcnt <= '0; bitn <= '0; last <= '0;
      tx <= '0; rx <= '0; is_rd <= 1'b0; hi <= 1'b0;
      rsp_done <= 1'b0; rsp_err <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      case (st)
        IDLE: if (acc) begin
          if (rsv) rsp_err <= 1'b1;
          else begin
            st    <= XFER;
            hi    <= 1'b1;
            dcnt  <= '0;
            bitn  <= '0;
            rx    <= '0;
            tx    <= {1'b1, req_cmd, req_addr, req_cmd[3] ? 32'd0 : req_wdata};
            is_rd <= (req_cmd == CMD_RD);
            last  <= !req_cmd[3] ? 6'd40 : (req_cmd == CMD_RD) ? 6'd41 : 6'd8;
          end
        end
        XFER: begin
          dcnt <= tick ? '0 : dcnt + 1'b1;
          if (tick) begin
            if (hi) begin
              hi <= 1'b0;
              if (rd_win && bitn != 6'd8) rx <= {rx[30:0], sda_i};
            end else if (bitn == last) begin
              st       <= LOCK;
              lcnt     <= '0;
              is_rd    <= 1'b0;
              rsp_done <= 1'b1;
            end else begin
              bitn <= bitn + 1'b1;
              hi   <= 1'b1;
              tx   <= {tx[38:0], 1'b0};
            end
          end
        end
        default: begin
          if (lcnt == LW'(LOCKOUT - 1)) st <= IDLE;
          else lcnt <= lcnt + 1'b1;
        end
      endcase
    end
  end

  // R4
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_o) || !$stable(sda_oe)) |-> $rose(scl));

  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl || rsp_done) |-> !req_ready);

  // R8
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_cmd == CMD_RSV) |=> (rsp_err && req_ready && !scl));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R5
  trailer_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (sda_oe && !sda_o));
endmodule

// File: tb/ee2w_host_test.sv
module ee2w_host_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;
  localparam int LOCKOUT = 50;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, sda_i = 0;
  logic [3:0] req_cmd = 0;
  logic [2:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_done, rsp_err, scl, sda_o, sda_oe;
  logic [31:0] rsp_rdata;

  int checks = 0, fails = 0;
  int nrec = 0, tidx = 0;
  logic rec_v[64], rec_oe[64];
  logic [3:0] tgt_cmd = 0;
  logic [31:0] tgt_rd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ee2w_host #(.DIV(DIV), .LOCKOUT(LOCKOUT)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .scl(scl), .sda_o(sda_o), .sda_oe(sda_oe), .sda_i(sda_i));

  always @(negedge scl) begin
    if (nrec < 64) begin rec_v[nrec] = sda_o; rec_oe[nrec] = sda_oe; end
    nrec++;
  end

  always @(posedge scl) begin
    if (tgt_cmd == 4'b1100 && tidx >= 9 && tidx <= 40) sda_i <= tgt_rd[40-tidx];
    else sda_i <= 1'b0;
    tidx++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int nbits(input logic [3:0] c);
    if (!c[3]) return 41;
    if (c == 4'b1100) return 42;
    return 9;
  endfunction

  function automatic logic [1:0] exp_bit(input logic [3:0] c, input logic [2:0] a,
                                         input logic [31:0] w, input int i);
    logic [7:0] hdr;
    hdr = {1'b1, c, a};
    if (i < 8) return {1'b1, hdr[7-i]};
    if (i == nbits(c) - 1) return 2'b10;
    if (c == 4'b1100) return 2'b00;
    return {1'b1, w[39-i]};
  endfunction

  function automatic string tag_of(input logic [3:0] c, input int i);
    if (i < 8) return "R2";
    if (i == nbits(c) - 1) return (nbits(c) == 9) ? "R7" : "R5";
    if (c == 4'b1100) return "R6";
    return "R3";
  endfunction

  task automatic run_txn(input logic [3:0] c, input logic [2:0] a,
                         input logic [31:0] w, input logic [31:0] rd);
    int n, k;
    bit busy_ok;
    logic [1:0] e;
    while (!req_ready) @(negedge clk);
    tgt_cmd = c; tgt_rd = rd; tidx = 0; nrec = 0;
    req_cmd = c; req_addr = a; req_wdata = w; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (c == 4'b1101) begin
      chk(rsp_err === 1'b1, "R8", "err pulse", rsp_err, 1);
      chk(req_ready === 1'b1, "R8", "ready kept", req_ready, 1);
      repeat (2*DIV+2) @(negedge clk);
      chk(nrec == 0 && tidx == 0 && scl === 1'b0, "R8", "no scl activity", nrec, 0);
      chk(rsp_err === 1'b0 && rsp_done === 1'b0, "R8", "no done, err one cycle", {rsp_err, rsp_done}, 0);
      return;
    end
    n = 0; busy_ok = 1;
    while (rsp_done !== 1'b1 && n < 1000) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk); n++;
    end
    chk(n == 2*DIV*nbits(c), "R9", "done cycle", n, 2*DIV*nbits(c));
    chk(busy_ok, "R11", "ready low in frame", busy_ok, 1);
    chk(rsp_rdata === ((c == 4'b1100) ? rd : 32'd0), "R10", "rdata", rsp_rdata,
        (c == 4'b1100) ? rd : 32'd0);
    chk(nrec == nbits(c), "R4", "scl clock count", nrec, nbits(c));
    for (int i = 0; i < nbits(c) && i < 64; i++) begin
      e = exp_bit(c, a, w, i);
      chk(rec_oe[i] === e[1] && (!e[1] || rec_v[i] === e[0]), tag_of(c, i),
          $sformatf("bit %0d {oe,val}", i), {rec_oe[i], rec_v[i]}, e);
    end
    @(negedge clk);
    chk(rsp_done === 1'b0, "R9", "done one cycle", rsp_done, 0);
    k = 1;
    while (!req_ready && k < 10000) begin @(negedge clk); k++; end
    chk(k == LOCKOUT, "R11", "lockout length", k, LOCKOUT);
    chk(scl === 1'b0 && sda_oe === 1'b1 && sda_o === 1'b0, "R4", "idle line", {scl, sda_oe, sda_o}, 3'b010);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned s;
    logic [3:0] cmds[8];
    s = $urandom(32'd2025);
    cmds = '{4'b0100, 4'b0101, 4'b0110, 4'b0111, 4'b1100, 4'b1101, 4'b1110, 4'b1111};
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && scl === 1'b0 && sda_o === 1'b0 && sda_oe === 1'b1 &&
        rsp_done === 1'b0 && rsp_err === 1'b0, "R1", "reset state",
        {req_ready, scl, sda_o, sda_oe, rsp_done, rsp_err}, 6'b100100);
    rst_n = 1;
    @(negedge clk);
    run_txn(4'b0110, 3'b101, 32'hFFFF_FFFF, 0);
    run_txn(4'b1100, 3'b111, 0, 32'hFFFF_FFFF);
    run_txn(4'b1100, 3'b000, 0, 32'h8000_0001);
    run_txn(4'b1101, 3'b010, 32'h1234_5678, 0);
    run_txn(4'b1110, 3'b011, 32'hDEAD_BEEF, 0);
    run_txn(4'b1000, 3'b001, 32'hCAFE_F00D, 0);
    run_txn(4'b0100, 3'b000, 32'h0000_0000, 0);
    for (int t = 0; t < 30; t++)
      run_txn(cmds[$urandom_range(0, 7)], 3'($urandom), $urandom, $urandom);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule